// File: doc/BRIEF.md
# Slave Wait-State Timing Generator

This block sits between a synchronous memory-mapped master port and a simple slave peripheral that has no handshake of its own. The master presents an address, byte enables, a read or write command and write data, and keeps them steady for as long as the stall line is high. The generator works out how long the transfer must take from three cycle counts: setup, wait and hold. Reads and writes each have their own set of counts. It keeps the master stalled until the last cycle of that span. Toward the slave it drives a chip select for the whole span. It drives a read or write strobe only during the wait cycles and the single access cycle that follows them.

A transfer walks through the named states SETUP, WAIT, ACCESS and HOLD, and it skips any state whose count is zero. IDLE is the resting state. The first cycle of a transfer is served from IDLE: the phase for that cycle is chosen combinationally from the counts, so that a transfer with all counts at zero finishes in the same cycle it is asked for. The transitions are as follows:
- IDLE goes to SETUP, WAIT or ACCESS on a request.
- SETUP goes to WAIT, or to ACCESS when the wait count is zero.
- WAIT goes to ACCESS.
- ACCESS goes to HOLD, or back to IDLE when the hold count is zero.
- HOLD goes to IDLE.

A new request may start in the cycle right after the previous one completes.

Top module: `wstg_top`

## Requirements
- R1: With no read or write request pending, the stall output, chip select, read strobe and write strobe are all low, both after reset and between transfers.
- R2: A transfer lasts setup + wait + 1 + hold cycles, counted from the first cycle the request is seen. The stall output is high in every one of those cycles except the last, and it is high already in the first cycle unless all three counts are zero.
- R3: When all three counts of an operation are zero, the transfer completes in the single cycle it is requested, and the stall output stays low.
- R4: During a read, the read strobe is high exactly in the wait cycles and in the access cycle, and it is low in setup and hold cycles. The write strobe stays low.
- R5: During a write, the write strobe is high exactly in the wait cycles and in the access cycle, and it is low in setup and hold cycles. The read strobe stays low.
- R6: The chip select is high in every cycle of a transfer, including setup and hold.
- R7: In the cycle where the stall output drops on a read, the read data equals what the slave returned in the access cycle. With a read hold of zero it is passed straight through. Otherwise it is the value registered at the end of the access cycle.
- R8: Address, byte enables and write data are forwarded unchanged to the slave throughout the transfer.
- R9: A request with read and write both high is carried out as a read: read counts, read strobe, no write strobe.
- R10: A new request presented in the cycle after a completion starts at once and gets the full setup, wait and hold timing.
- R11: Read and write timing come from separate count sets, so the same block can stretch reads and writes by different amounts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_addr | input | ADDR_W | Master address |
| m_be | input | BE_W | Master byte enables |
| m_read | input | 1 | Master read request |
| m_write | input | 1 | Master write request |
| m_wdata | input | DATA_W | Master write data |
| m_waitreq | output | 1 | Stall toward master; high while the transfer is not finished |
| m_rdata | output | DATA_W | Read data, valid in the cycle the stall drops on a read |
| s_cs | output | 1 | Slave chip select |
| s_addr | output | ADDR_W | Address toward slave |
| s_be | output | BE_W | Byte enables toward slave |
| s_rd | output | 1 | Slave read strobe |
| s_wr | output | 1 | Slave write strobe |
| s_wdata | output | DATA_W | Write data toward slave |
| s_rdata | input | DATA_W | Read data from slave |

## Verification
The bench runs three instances with different count sets: mixed small counts, all zeros, and long hold and wait phases. This exercises the zero-length, pass-through and registered read paths. An off-by-one in a phase counter would show up as the stall dropping one cycle early or late. A strobe that leaks into setup or hold would be caught when the bench compares strobes in every cycle. The slave model returns data only while the read strobe is high, so a design that presents data after hold without having registered it returns zero. Simultaneous read and write requests and back-to-back transfers are also tried; a design that gave write priority, or that lost a cycle when re-entering from IDLE, would fail there.

// File: rtl/wstg_pkg.sv
package wstg_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_WAIT,
        PH_ACCESS,
        PH_HOLD
    } phase_e;

    // Phase a new transfer starts in, given its setup and wait counts.
    function automatic phase_e entry_phase(input int unsigned setup_n,
                                           input int unsigned wait_n);
        if (setup_n != 0)      return PH_SETUP;
        else if (wait_n != 0)  return PH_WAIT;
        else                   return PH_ACCESS;
    endfunction

endpackage

// File: rtl/wstg_phase_fsm.sv
module wstg_phase_fsm
    import wstg_pkg::*;
#(
    parameter int RD_SETUP = 1,
    parameter int RD_WAIT  = 1,
    parameter int RD_HOLD  = 0,
    parameter int WR_SETUP = 1,
    parameter int WR_WAIT  = 0,
    parameter int WR_HOLD  = 1,
    parameter int CNT_W    = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req,
    input  logic   req_rd,
    output phase_e cur_phase,
    output logic   cur_rd,
    output logic   last_cyc
);

    phase_e            st_q, st_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              op_rd_q, op_rd_d;
    logic [CNT_W-1:0]  cur_cnt;
    logic [CNT_W-1:0]  n_setup, n_wait, n_hold;
    phase_e            first_ph;

    // Operation and counts of the transfer being served this cycle.
    always_comb begin
        cur_rd   = (st_q == PH_IDLE) ? req_rd : op_rd_q;
        n_setup  = cur_rd ? CNT_W'(RD_SETUP) : CNT_W'(WR_SETUP);
        n_wait   = cur_rd ? CNT_W'(RD_WAIT)  : CNT_W'(WR_WAIT);
        n_hold   = cur_rd ? CNT_W'(RD_HOLD)  : CNT_W'(WR_HOLD);
        first_ph = entry_phase(int'(n_setup), int'(n_wait));
        if (st_q == PH_IDLE) begin
            cur_phase = req ? first_ph : PH_IDLE;
            cur_cnt   = '0;
        end else begin
            cur_phase = st_q;
            cur_cnt   = cnt_q;
        end
    end

    // Next state, phase counter and end-of-transfer flag.
    always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_q;
        op_rd_d  = op_rd_q;
        last_cyc = 1'b0;
        unique case (cur_phase)
            PH_IDLE: begin
                st_d  = PH_IDLE;
                cnt_d = '0;
            end
            PH_SETUP: begin
                op_rd_d = cur_rd;
                if (cur_cnt == n_setup - 1'b1) begin
                    st_d  = (n_wait != '0) ? PH_WAIT : PH_ACCESS;
                    cnt_d = '0;
                end else begin
                    st_d  = PH_SETUP;
                    cnt_d = cur_cnt + 1'b1;
                end
            end
            PH_WAIT: begin
                op_rd_d = cur_rd;
                if (cur_cnt == n_wait - 1'b1) begin
                    st_d  = PH_ACCESS;
                    cnt_d = '0;
                end else begin
                    st_d  = PH_WAIT;
                    cnt_d = cur_cnt + 1'b1;
                end
            end
            PH_ACCESS: begin
                op_rd_d = cur_rd;
                cnt_d   = '0;
                if (n_hold != '0) begin
                    st_d = PH_HOLD;
                end else begin
                    st_d     = PH_IDLE;
                    last_cyc = 1'b1;
                end
            end
            PH_HOLD: begin
                if (cur_cnt == n_hold - 1'b1) begin
                    st_d     = PH_IDLE;
                    cnt_d    = '0;
                    last_cyc = 1'b1;
                end else begin
                    st_d  = PH_HOLD;
                    cnt_d = cur_cnt + 1'b1;
                end
            end
            default: begin
                st_d  = PH_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= PH_IDLE;
            cnt_q   <= '0;
            op_rd_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            cnt_q   <= cnt_d;
            op_rd_q <= op_rd_d;
        end
    end

endmodule

// File: rtl/wstg_strobe_gen.sv
module wstg_strobe_gen
    import wstg_pkg::*;
(
    input  phase_e cur_phase,
    input  logic   cur_rd,
    output logic   cs,
    output logic   rd_stb,
    output logic   wr_stb
);

    logic strobe_window;

    always_comb begin
        cs            = (cur_phase != PH_IDLE);
        strobe_window = (cur_phase == PH_WAIT) || (cur_phase == PH_ACCESS);
        rd_stb        = strobe_window && cur_rd;
        wr_stb        = strobe_window && !cur_rd;
    end

endmodule

// File: rtl/wstg_rdata_path.sv
module wstg_rdata_path
    import wstg_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int RD_HOLD = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            cur_phase,
    input  logic              cur_rd,
    input  logic [DATA_W-1:0] slv_data,
    output logic [DATA_W-1:0] mst_data
);

    generate
        if (RD_HOLD == 0) begin : g_pass
            // Access cycle is also the completion cycle.
            assign mst_data = slv_data;
        end else begin : g_reg
            logic [DATA_W-1:0] held_q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    held_q <= '0;
                else if (cur_phase == PH_ACCESS && cur_rd)
                    held_q <= slv_data;
            end
            assign mst_data = held_q;
        end
    endgenerate

endmodule

// File: rtl/wstg_top.sv
module wstg_top
    import wstg_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    parameter int BE_W     = DATA_W / 8,
    parameter int RD_SETUP = 1,
    parameter int RD_WAIT  = 1,
    parameter int RD_HOLD  = 0,
    parameter int WR_SETUP = 1,
    parameter int WR_WAIT  = 0,
    parameter int WR_HOLD  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic [BE_W-1:0]   m_be,
    input  logic              m_read,
    input  logic              m_write,
    input  logic [DATA_W-1:0] m_wdata,
    output logic              m_waitreq,
    output logic [DATA_W-1:0] m_rdata,
    output logic              s_cs,
    output logic [ADDR_W-1:0] s_addr,
    output logic [BE_W-1:0]   s_be,
    output logic              s_rd,
    output logic              s_wr,
    output logic [DATA_W-1:0] s_wdata,
    input  logic [DATA_W-1:0] s_rdata
);

    localparam int MAX_RD = (RD_SETUP > RD_WAIT) ?
                            ((RD_SETUP > RD_HOLD) ? RD_SETUP : RD_HOLD) :
                            ((RD_WAIT  > RD_HOLD) ? RD_WAIT  : RD_HOLD);
    localparam int MAX_WR = (WR_SETUP > WR_WAIT) ?
                            ((WR_SETUP > WR_HOLD) ? WR_SETUP : WR_HOLD) :
                            ((WR_WAIT  > WR_HOLD) ? WR_WAIT  : WR_HOLD);
    localparam int MAX_N  = (MAX_RD > MAX_WR) ? MAX_RD : MAX_WR;
    localparam int CNT_W  = $clog2(MAX_N + 1) + 1;

    phase_e cur_phase;
    logic   cur_rd;
    logic   last_cyc;
    logic   req;

    assign req = m_read || m_write;

    wstg_phase_fsm #(
        .RD_SETUP (RD_SETUP),
        .RD_WAIT  (RD_WAIT),
        .RD_HOLD  (RD_HOLD),
        .WR_SETUP (WR_SETUP),
        .WR_WAIT  (WR_WAIT),
        .WR_HOLD  (WR_HOLD),
        .CNT_W    (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_rd    (m_read),
        .cur_phase (cur_phase),
        .cur_rd    (cur_rd),
        .last_cyc  (last_cyc)
    );

    wstg_strobe_gen u_stb (
        .cur_phase (cur_phase),
        .cur_rd    (cur_rd),
        .cs        (s_cs),
        .rd_stb    (s_rd),
        .wr_stb    (s_wr)
    );

    wstg_rdata_path #(
        .DATA_W  (DATA_W),
        .RD_HOLD (RD_HOLD)
    ) u_rdp (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur_phase (cur_phase),
        .cur_rd    (cur_rd),
        .slv_data  (s_rdata),
        .mst_data  (m_rdata)
    );

    assign m_waitreq = (cur_phase != PH_IDLE) && !last_cyc;
    assign s_addr    = m_addr;
    assign s_be      = m_be;
    assign s_wdata   = m_wdata;

endmodule

// File: rtl/wstg_checker.sv
module wstg_checker #(
    parameter int RD_HOLD = 0,
    parameter int WR_HOLD = 1
) (
    input logic clk,
    input logic rst_n,
    input logic m_read,
    input logic m_write,
    input logic m_waitreq,
    input logic s_cs,
    input logic s_rd,
    input logic s_wr
);

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_rd && s_wr)); // R9

    AST_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rd || s_wr) |-> s_cs); // R6

    AST_STALL_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        m_waitreq |-> (m_read || m_write)); // R1

    AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ((m_read || m_write) && !m_waitreq) |=> ((m_read || m_write) || !s_cs)); // R1

    AST_WR_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (m_write && !m_read && !m_waitreq && (WR_HOLD > 0)) |-> !s_wr); // R5

    AST_RD_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (m_read && !m_waitreq && (RD_HOLD > 0)) |-> !s_rd); // R4

endmodule

bind wstg_top wstg_checker #(
    .RD_HOLD (RD_HOLD),
    .WR_HOLD (WR_HOLD)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .m_read    (m_read),
    .m_write   (m_write),
    .m_waitreq (m_waitreq),
    .s_cs      (s_cs),
    .s_rd      (s_rd),
    .s_wr      (s_wr)
);

// File: tb/wstg_top_test.sv
module wstg_top_test;

    localparam int NI = 3;
    localparam int RS [NI] = '{1, 0, 2};
    localparam int RW [NI] = '{1, 0, 0};
    localparam int RH [NI] = '{0, 0, 2};
    localparam int WS [NI] = '{1, 0, 0};
    localparam int WW [NI] = '{0, 0, 2};
    localparam int WH [NI] = '{1, 0, 0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [15:0] m_addr  [NI];
    logic [3:0]  m_be    [NI];
    logic        m_read  [NI];
    logic        m_write [NI];
    logic [31:0] m_wdata [NI];
    logic        m_waitreq [NI];
    logic [31:0] m_rdata [NI];
    logic        s_cs    [NI];
    logic [15:0] s_addr  [NI];
    logic [3:0]  s_be    [NI];
    logic        s_rd    [NI];
    logic        s_wr    [NI];
    logic [31:0] s_wdata [NI];
    logic [31:0] s_rdata [NI];

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    function automatic logic [31:0] slave_val(input logic [15:0] a);
        return {~a, a};
    endfunction

    // Slave model: data only while its read strobe is high.
    assign s_rdata[0] = s_rd[0] ? slave_val(s_addr[0]) : 32'h0;
    assign s_rdata[1] = s_rd[1] ? slave_val(s_addr[1]) : 32'h0;
    assign s_rdata[2] = s_rd[2] ? slave_val(s_addr[2]) : 32'h0;

    wstg_top #(.RD_SETUP(RS[0]), .RD_WAIT(RW[0]), .RD_HOLD(RH[0]),
               .WR_SETUP(WS[0]), .WR_WAIT(WW[0]), .WR_HOLD(WH[0])) uut (
        .clk(clk), .rst_n(rst_n), .m_addr(m_addr[0]), .m_be(m_be[0]),
        .m_read(m_read[0]), .m_write(m_write[0]), .m_wdata(m_wdata[0]),
        .m_waitreq(m_waitreq[0]), .m_rdata(m_rdata[0]), .s_cs(s_cs[0]),
        .s_addr(s_addr[0]), .s_be(s_be[0]), .s_rd(s_rd[0]), .s_wr(s_wr[0]),
        .s_wdata(s_wdata[0]), .s_rdata(s_rdata[0]));

    wstg_top #(.RD_SETUP(RS[1]), .RD_WAIT(RW[1]), .RD_HOLD(RH[1]),
               .WR_SETUP(WS[1]), .WR_WAIT(WW[1]), .WR_HOLD(WH[1])) uut_zero (
        .clk(clk), .rst_n(rst_n), .m_addr(m_addr[1]), .m_be(m_be[1]),
        .m_read(m_read[1]), .m_write(m_write[1]), .m_wdata(m_wdata[1]),
        .m_waitreq(m_waitreq[1]), .m_rdata(m_rdata[1]), .s_cs(s_cs[1]),
        .s_addr(s_addr[1]), .s_be(s_be[1]), .s_rd(s_rd[1]), .s_wr(s_wr[1]),
        .s_wdata(s_wdata[1]), .s_rdata(s_rdata[1]));

    wstg_top #(.RD_SETUP(RS[2]), .RD_WAIT(RW[2]), .RD_HOLD(RH[2]),
               .WR_SETUP(WS[2]), .WR_WAIT(WW[2]), .WR_HOLD(WH[2])) uut_long (
        .clk(clk), .rst_n(rst_n), .m_addr(m_addr[2]), .m_be(m_be[2]),
        .m_read(m_read[2]), .m_write(m_write[2]), .m_wdata(m_wdata[2]),
        .m_waitreq(m_waitreq[2]), .m_rdata(m_rdata[2]), .s_cs(s_cs[2]),
        .s_addr(s_addr[2]), .s_be(s_be[2]), .s_rd(s_rd[2]), .s_wr(s_wr[2]),
        .s_wdata(s_wdata[2]), .s_rdata(s_rdata[2]));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Called just after a rising edge; checks one idle cycle.
    task automatic idle_cycle(input int i);
        m_read[i]  = 1'b0;
        m_write[i] = 1'b0;
        @(negedge clk);
        chk($sformatf("R1 stall u%0d", i), 32'(m_waitreq[i]), 32'd0);
        chk($sformatf("R1 cs u%0d", i),    32'(s_cs[i]),      32'd0);
        chk($sformatf("R1 rd u%0d", i),    32'(s_rd[i]),      32'd0);
        chk($sformatf("R1 wr u%0d", i),    32'(s_wr[i]),      32'd0);
        @(posedge clk); #1;
    endtask

    // Called just after a rising edge; runs one transfer against the model.
    task automatic xfer(input int i, input string ctx, input logic rd, input logic wr,
                        input logic [15:0] a, input logic [31:0] d);
        int s, w, h, len;
        logic op_rd;
        op_rd = rd;
        s = op_rd ? RS[i] : WS[i];
        w = op_rd ? RW[i] : WW[i];
        h = op_rd ? RH[i] : WH[i];
        len = s + w + 1 + h;
        m_addr[i]  = a;
        m_be[i]    = a[3:0];
        m_wdata[i] = d;
        m_read[i]  = rd;
        m_write[i] = wr;
        for (int k = 0; k < len; k++) begin
            bit in_win;
            in_win = (k >= s) && (k <= s + w);
            @(negedge clk);
            chk($sformatf("%s R2 stall u%0d k%0d", ctx, i, k), 32'(m_waitreq[i]),
                32'(k != len - 1));
            chk($sformatf("%s R6 cs u%0d k%0d", ctx, i, k), 32'(s_cs[i]), 32'd1);
            chk($sformatf("%s R4 rd u%0d k%0d", ctx, i, k), 32'(s_rd[i]),
                32'(op_rd && in_win));
            chk($sformatf("%s R5 wr u%0d k%0d", ctx, i, k), 32'(s_wr[i]),
                32'(!op_rd && in_win));
            if (k == 0) begin
                chk($sformatf("%s R8 addr u%0d", ctx, i), 32'(s_addr[i]), 32'(a));
                chk($sformatf("%s R8 be u%0d", ctx, i), 32'(s_be[i]), 32'(a[3:0]));
                chk($sformatf("%s R8 wdata u%0d", ctx, i), s_wdata[i], d);
            end
            if (k == len - 1 && op_rd)
                chk($sformatf("%s R7 rdata u%0d", ctx, i), m_rdata[i], slave_val(a));
            @(posedge clk); #1;
        end
        m_read[i]  = 1'b0;
        m_write[i] = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < NI; i++) begin
            m_addr[i] = '0; m_be[i] = '0; m_read[i] = 1'b0;
            m_write[i] = 1'b0; m_wdata[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state on every instance
        for (int i = 0; i < NI; i++) idle_cycle(i);

        // Mixed counts: read 1/1/0, write 1/0/1
        xfer(0, "R2", 1'b1, 1'b0, 16'h1234, 32'h0);
        idle_cycle(0);
        xfer(0, "R5", 1'b0, 1'b1, 16'h00A5, 32'hDEAD_BEEF);
        idle_cycle(0);
        xfer(0, "R9", 1'b1, 1'b1, 16'h0F0F, 32'h1111_2222);
        idle_cycle(0);
        // R10: back-to-back, no idle gap
        xfer(0, "R10", 1'b1, 1'b0, 16'h2468, 32'h0);
        xfer(0, "R10", 1'b0, 1'b1, 16'h1357, 32'hCAFE_F00D);
        xfer(0, "R10", 1'b1, 1'b0, 16'h8001, 32'h0);
        idle_cycle(0);

        // All-zero counts: single-cycle transfers
        xfer(1, "R3", 1'b1, 1'b0, 16'h5555, 32'h0);
        xfer(1, "R3", 1'b0, 1'b1, 16'hAAAA, 32'h7777_0000);
        xfer(1, "R9", 1'b1, 1'b1, 16'h0102, 32'h3333_4444);
        idle_cycle(1);

        // Long phases, different per operation (R11); registered read data
        xfer(2, "R11", 1'b1, 1'b0, 16'hBEEF, 32'h0);
        idle_cycle(2);
        xfer(2, "R11", 1'b0, 1'b1, 16'h4321, 32'h9999_8888);
        xfer(2, "R7", 1'b1, 1'b0, 16'h7E57, 32'h0);
        idle_cycle(2);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule